// File: doc/BRIEF.md
# SMBus Host Status and Abort Register Pair

This block sits between a software-facing byte register port and the transaction engine of an SMBus master. It holds two registers. The status register carries a read-only busy bit and sticky flags for per-byte progress, clean completion, missing acknowledge, lost arbitration and forced termination. The control register carries an interrupt enable, a level-held abort bit and a self-clearing launch bit.

Software launches a transaction by writing the launch bit while the host is idle. The block then raises busy and sends a single-cycle start pulse to the engine. The engine reports progress and termination on event inputs, and the block turns them into flags. Setting the abort bit ends an active transaction at once and records a forced termination. Flags stay set until software writes ones to them. An interrupt request is raised while enabled completion or error flags are pending.

Top module: `smbus_host_status`

## Requirements
- R1: Address 0 is status: bit7 byte-done, bit4 failed, bit3 bus error, bit2 device error, bit1 complete, bit0 busy, and bits 6 and 5 read 0. Address 1 is control: bit0 interrupt enable, bit1 abort, bit6 launch, and the launch bit always reads 0.
- R2: A status write of one to bit 7, 4, 3, 2 or 1 clears that flag, and a zero leaves it unchanged. A flag set event in the same cycle as its clear wins.
- R3: Busy (status bit0) cannot be changed by a status write.
- R4: A control write with the launch bit set, while idle and with abort not set by that write, raises busy at that clock edge and pulses `eng_start` high for exactly one cycle.
- R5: A launch while busy, or with the abort bit set in the same write, is ignored: no `eng_start` pulse and no change of busy.
- R6: A control write that sets abort while busy drops busy at that edge and sets the failed flag, and the complete flag is not set even if `eng_done` arrives in that cycle. `eng_abort` follows the stored abort bit.
- R7: `eng_done` while busy, with no error input, sets complete and drops busy.
- R8: `eng_nack` while busy sets device error, and `eng_arb_lost` sets bus error. Either one ends busy, and complete is not set in that cycle.
- R9: `eng_byte_done` while busy sets byte-done and leaves busy high.
- R10: Engine events while idle change no flag.
- R11: Flags stay set after busy drops until software clears them.
- R12: `irq` = interrupt enable AND (complete OR failed OR bus error OR device error). Byte-done does not raise `irq`.
- R13: Synchronous reset clears busy, all flags and the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_abort | output | 1 | Stored abort request to the engine |
| eng_done | input | 1 | Engine: transaction finished |
| eng_byte_done | input | 1 | Engine: one byte transferred |
| eng_nack | input | 1 | Engine: no acknowledge from the target |
| eng_arb_lost | input | 1 | Engine: arbitration lost |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets same-cycle collisions. In one case a completion event meets a software clear of the same flag, and a design that lets the clear win loses a completion. In another, abort meets `eng_done`, and a design that lets done through reports success for a killed transaction. Launch while busy, and launch together with abort, must not produce a second start pulse, which would restart the engine mid-transfer. Events while idle, writes of one to busy and writes of zero to set flags must leave the status byte unchanged. A wrong gating would show up there as phantom flags or a stuck or cleared busy bit.

// File: rtl/smbhs_pkg.sv
package smbhs_pkg;
  localparam int unsigned REG_W = 8;

  // status bit positions
  localparam int unsigned SB_BYTE   = 7;
  localparam int unsigned SB_FAIL   = 4;
  localparam int unsigned SB_BUSERR = 3;
  localparam int unsigned SB_DEVERR = 2;
  localparam int unsigned SB_DONE   = 1;
  localparam int unsigned SB_BUSY   = 0;

  // control bit positions
  localparam int unsigned CB_IEN   = 0;
  localparam int unsigned CB_KILL  = 1;
  localparam int unsigned CB_START = 6;

  typedef struct packed {
    logic byte_done;
    logic failed;
    logic bus_err;
    logic dev_err;
    logic done;
  } flags_t;

  // clear every flag whose bit is written with one
  function automatic flags_t apply_w1c(flags_t f, logic [REG_W-1:0] wd);
    flags_t r;
    r.byte_done = f.byte_done & ~wd[SB_BYTE];
    r.failed    = f.failed    & ~wd[SB_FAIL];
    r.bus_err   = f.bus_err   & ~wd[SB_BUSERR];
    r.dev_err   = f.dev_err   & ~wd[SB_DEVERR];
    r.done      = f.done      & ~wd[SB_DONE];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(flags_t f, logic busy);
    logic [REG_W-1:0] s;
    s = '0;
    s[SB_BYTE]   = f.byte_done;
    s[SB_FAIL]   = f.failed;
    s[SB_BUSERR] = f.bus_err;
    s[SB_DEVERR] = f.dev_err;
    s[SB_DONE]   = f.done;
    s[SB_BUSY]   = busy;
    return s;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(logic ien, logic kill);
    logic [REG_W-1:0] c;
    c = '0;
    c[CB_IEN]  = ien;
    c[CB_KILL] = kill;
    return c;
  endfunction

  function automatic logic irq_of(flags_t f, logic ien);
    return ien & (f.done | f.failed | f.bus_err | f.dev_err);
  endfunction
endpackage

// File: rtl/hsc_ctrl.sv
module hsc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic wr_ien,
  input  logic wr_kill,
  input  logic wr_start,
  input  logic eng_done,
  input  logic eng_byte_done,
  input  logic eng_nack,
  input  logic eng_arb_lost,
  output logic busy,
  output logic ien,
  output logic kill,
  output logic start_pulse,
  output logic abort_evt,
  output logic done_ok_evt,
  output logic nack_evt,
  output logic arb_evt,
  output logic byte_evt
);
  logic busy_q, ien_q, kill_q, start_q;
  logic kill_now, start_req, start_acc, end_evt;

  assign kill_now    = ctrl_wr ? wr_kill : kill_q;
  assign start_req   = ctrl_wr & wr_start;
  assign start_acc   = start_req & ~busy_q & ~kill_now;
  assign abort_evt   = busy_q & kill_now;
  assign nack_evt    = busy_q & ~abort_evt & eng_nack;
  assign arb_evt     = busy_q & ~abort_evt & eng_arb_lost;
  assign byte_evt    = busy_q & ~abort_evt & eng_byte_done;
  assign done_ok_evt = busy_q & ~abort_evt & eng_done & ~eng_nack & ~eng_arb_lost;
  assign end_evt     = abort_evt | nack_evt | arb_evt | (busy_q & eng_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ien_q   <= 1'b0;
      kill_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_acc;
      if (ctrl_wr) begin
        ien_q  <= wr_ien;
        kill_q <= wr_kill;
      end
      if (start_acc)    busy_q <= 1'b1;
      else if (end_evt) busy_q <= 1'b0;
    end
  end

  assign busy        = busy_q;
  assign ien         = ien_q;
  assign kill        = kill_q;
  assign start_pulse = start_q;

  // R4: accepted launch raises busy and pulses start
  p_launch_r4: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> (busy_q && start_q));
  // R5: launch while busy gives no start pulse
  p_launch_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_req) |=> !start_q);
  // R6: abort ends busy at once
  p_abort_drops_r6: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> !busy_q);
  // R4: start pulse lasts one cycle
  p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
endmodule

// File: rtl/hsc_flags.sv
module hsc_flags
  import smbhs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sts_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_byte,
  input  logic             set_fail,
  input  logic             set_bus,
  input  logic             set_dev,
  input  logic             set_done,
  output flags_t           flags
);
  flags_t flags_q, cleared, set_v;

  always_comb begin
    cleared = sts_wr ? apply_w1c(flags_q, wdata) : flags_q;
    set_v.byte_done = set_byte;
    set_v.failed    = set_fail;
    set_v.bus_err   = set_bus;
    set_v.dev_err   = set_dev;
    set_v.done      = set_done;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= cleared | set_v;
  end

  assign flags = flags_q;

  // R11: complete stays set until written with one
  p_sticky_done_r11: assert property (@(posedge clk) disable iff (rst)
    (flags_q.done && !(sts_wr && wdata[SB_DONE])) |=> flags_q.done);
  // R2: a clear without a concurrent set removes the flag
  p_w1c_done_r2: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && wdata[SB_DONE] && !set_done) |=> !flags_q.done);
  // R2: set wins over clear
  p_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
    set_fail |=> flags_q.failed);
endmodule

// File: rtl/smbus_host_status.sv
module smbus_host_status
  import smbhs_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          eng_start,
  output logic          eng_abort,
  input  logic          eng_done,
  input  logic          eng_byte_done,
  input  logic          eng_nack,
  input  logic          eng_arb_lost,
  output logic          irq
);
  localparam logic ADDR_STS  = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  logic   sts_wr, ctrl_wr;
  logic   busy, ien, kill;
  logic   abort_evt, done_ok_evt, nack_evt, arb_evt, byte_evt;
  flags_t flags;

  assign sts_wr  = reg_wr & (reg_addr == ADDR_STS);
  assign ctrl_wr = reg_wr & (reg_addr == ADDR_CTRL);

  hsc_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .ctrl_wr       (ctrl_wr),
    .wr_ien        (reg_wdata[CB_IEN]),
    .wr_kill       (reg_wdata[CB_KILL]),
    .wr_start      (reg_wdata[CB_START]),
    .eng_done      (eng_done),
    .eng_byte_done (eng_byte_done),
    .eng_nack      (eng_nack),
    .eng_arb_lost  (eng_arb_lost),
    .busy          (busy),
    .ien           (ien),
    .kill          (kill),
    .start_pulse   (eng_start),
    .abort_evt     (abort_evt),
    .done_ok_evt   (done_ok_evt),
    .nack_evt      (nack_evt),
    .arb_evt       (arb_evt),
    .byte_evt      (byte_evt)
  );

  hsc_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .sts_wr   (sts_wr),
    .wdata    (reg_wdata),
    .set_byte (byte_evt),
    .set_fail (abort_evt),
    .set_bus  (arb_evt),
    .set_dev  (nack_evt),
    .set_done (done_ok_evt),
    .flags    (flags)
  );

  assign reg_rdata = (reg_addr == ADDR_STS) ? pack_status(flags, busy)
                                            : pack_ctrl(ien, kill);
  assign eng_abort = kill;
  assign irq       = irq_of(flags, ien);

  // R6: abort records a forced termination and no completion
  p_abort_fail_r6: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> (flags.failed && !busy));
  // R7: clean end sets complete
  p_done_ok_r7: assert property (@(posedge clk) disable iff (rst)
    done_ok_evt |=> (flags.done && !busy));
  // R8: error ends busy and sets its flag
  p_nack_r8: assert property (@(posedge clk) disable iff (rst)
    nack_evt |=> (flags.dev_err && !busy));
  // R3: status writes never raise busy
  p_busy_ro_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && sts_wr && !ctrl_wr) |=> !busy);
  // R12: irq needs a pending flag
  p_irq_src_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flags.done || flags.failed || flags.bus_err || flags.dev_err));
  // R13: reset clears state
  p_reset_r13: assert property (@(posedge clk)
    rst |=> (!busy && flags == '0 && !kill && !ien));
endmodule

// File: tb/smbus_host_status_tb.sv
module smbus_host_status_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       eng_start, eng_abort, irq;
  logic       eng_done = 1'b0, eng_byte_done = 1'b0, eng_nack = 1'b0, eng_arb_lost = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  smbus_host_status u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_abort(eng_abort), .eng_done(eng_done), .eng_byte_done(eng_byte_done),
    .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic chk_sts(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd(1'b0, v);
    check(tag, v, exp);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  // m = {arb_lost, nack, byte_done, done}
  task automatic ev(input logic [3:0] m);
    @(negedge clk);
    {eng_arb_lost, eng_nack, eng_byte_done, eng_done} = m;
    @(posedge clk);
    #1;
    {eng_arb_lost, eng_nack, eng_byte_done, eng_done} = 4'b0000;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk_sts("R13 status after reset", 8'h00);
    rd(1'b1, v);
    check("R13 control after reset", v, 8'h00);
    check("R13 irq after reset", {7'b0, irq}, 8'h00);
    check("R13 eng_start after reset", {7'b0, eng_start}, 8'h00);
  endtask

  task automatic t_launch_and_done;
    logic [7:0] v;
    wr(1'b1, 8'h41);
    chk_sts("R4 busy after launch", 8'h01);
    check("R4 start pulse", {7'b0, eng_start}, 8'h01);
    rd(1'b1, v);
    check("R1 launch bit reads zero", v, 8'h01);
    @(posedge clk); #1;
    check("R4 start pulse one cycle", {7'b0, eng_start}, 8'h00);
    wr(1'b1, 8'h41);
    check("R5 no start while busy", {7'b0, eng_start}, 8'h00);
    chk_sts("R5 busy unchanged", 8'h01);
    wr(1'b0, 8'h01);
    chk_sts("R3 busy read-only", 8'h01);
    ev(4'b0010);
    chk_sts("R9 byte-done keeps busy", 8'h81);
    check("R12 byte-done no irq", {7'b0, irq}, 8'h00);
    ev(4'b0001);
    chk_sts("R7 complete set busy low", 8'h82);
    check("R12 irq on complete", {7'b0, irq}, 8'h01);
    repeat (5) @(posedge clk);
    #1;
    chk_sts("R11 flags sticky", 8'h82);
    wr(1'b0, 8'h00);
    chk_sts("R2 zero write no effect", 8'h82);
    wr(1'b0, 8'h80);
    chk_sts("R2 clear byte-done only", 8'h02);
    wr(1'b1, 8'h00);
    check("R12 irq gated by enable", {7'b0, irq}, 8'h00);
    wr(1'b0, 8'h02);
    chk_sts("R2 clear complete", 8'h00);
  endtask

  task automatic t_idle_events;
    ev(4'b1111);
    chk_sts("R10 idle events ignored", 8'h00);
  endtask

  task automatic t_nack;
    wr(1'b1, 8'h41);
    ev(4'b0101);
    chk_sts("R8 nack sets dev err only", 8'h04);
    check("R12 irq on dev err", {7'b0, irq}, 8'h01);
    wr(1'b0, 8'h04);
    chk_sts("R2 clear dev err", 8'h00);
  endtask

  task automatic t_arb;
    wr(1'b1, 8'h41);
    ev(4'b1000);
    chk_sts("R8 arb loss sets bus err", 8'h08);
    wr(1'b0, 8'h08);
  endtask

  task automatic t_kill;
    wr(1'b1, 8'h41);
    wr(1'b1, 8'h03);
    chk_sts("R6 abort sets failed", 8'h10);
    check("R6 eng_abort follows bit", {7'b0, eng_abort}, 8'h01);
    wr(1'b1, 8'h43);
    check("R5 no start with abort", {7'b0, eng_start}, 8'h00);
    chk_sts("R5 stays idle with abort", 8'h10);
    wr(1'b1, 8'h01);
    check("R6 eng_abort released", {7'b0, eng_abort}, 8'h00);
    wr(1'b0, 8'h10);
    chk_sts("R2 clear failed", 8'h00);
    // abort and done in the same cycle
    wr(1'b1, 8'h41);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h03; eng_done = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = 8'h00; eng_done = 1'b0;
    chk_sts("R6 abort beats done", 8'h10);
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h10);
  endtask

  task automatic t_set_wins;
    wr(1'b1, 8'h41);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h02; eng_done = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = 8'h00; eng_done = 1'b0;
    chk_sts("R2 set wins over clear", 8'h02);
    wr(1'b0, 8'h02);
    chk_sts("R2 cleared afterwards", 8'h00);
  endtask

  task automatic t_midreset;
    wr(1'b1, 8'h43);
    ev(4'b0000);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    t_reset();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    t_reset();
    t_launch_and_done();
    t_idle_events();
    t_nack();
    t_arb();
    t_kill();
    t_set_wins();
    t_midreset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule